// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block collects interrupt events for a small 8-bit processor core and turns them into one vectored request. Six sources feed it. Three are single-cycle time-out strobes from on-chip timers. The other three come from two external pins: one pin produces a separate event on each edge direction, and the other produces an event only on its falling edge. Both pins pass through a synchroniser and a stability filter before any edge counts.

Every event sets a pending flag. A mask register holds one enable bit per source and a master enable. Among the requests that are pending and enabled, the one with the lowest source index wins. The controller raises a request line and presents the first byte address of that source's two-byte vector pair. When the core acknowledges, the winning flag is cleared and the master enable drops in the same cycle. The core's enable, disable and interrupt-return strobes drive the master enable. Software can write the per-source enables and can clear any set of pending flags.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While and after reset, `mask_q` reads 00h, `pend_q` reads 0 and `irq_req` is 0.
- R2: Pending bit i has this cause. Bit 0 is `tmr_tick[0]`, bit 1 is a falling edge on `ext_pin[0]`, bit 2 is `tmr_tick[1]`, bit 3 is a falling edge on `ext_pin[1]`, bit 4 is a rising edge on `ext_pin[0]`, and bit 5 is `tmr_tick[2]`. When source i wins, `irq_vec` equals 2 + 2*i.
- R3: Priority is fixed. Among the sources that are pending and enabled, the lowest index wins.
- R4: `irq_req` is 1 exactly when master enable `mask_q[7]` is 1 and some pending bit i has `mask_q[i]` set (i = 0 to 5).
- R5: A `mask_wr` pulse loads `mask_q[5:0]` from `mask_wdata[5:0]` in the following cycle. `mask_q[6]` always reads 0, and a mask write never changes `mask_q[7]`.
- R6: `ei_pulse` sets the master enable and `di_pulse` clears it. If both arrive in the same cycle, disable wins.
- R7: `ack` while `irq_req` is 1 clears the winner's pending bit and the master enable at the next edge. `ack` while `irq_req` is 0 changes nothing. Acknowledge-clear takes precedence over `ei_pulse` and `iret_pulse` in the same cycle.
- R8: `iret_pulse` sets the master enable, unless an acknowledge or a disable arrives in the same cycle.
- R9: A pending bit is set by its event even when that source or the master enable is masked. It stays set until it is acknowledged or cleared by software.
- R10: A `pend_clr` pulse clears every pending bit whose bit in `pend_clr_sel` is 1.
- R11: A pin edge counts only after the new synchronised level has held for `FILT_N` consecutive samples (default 2). A low or high pulse lasting one clock sets no pending bit. A rising edge on `ext_pin[1]` has no effect.
- R12: If a source event and a clear of the same pending bit arrive in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tmr_tick | input | 3 | Timer time-out strobes, one cycle each |
| ext_pin | input | 2 | Asynchronous external request pins, idle high |
| mask_wr | input | 1 | Write strobe for the per-source enables |
| mask_wdata | input | 8 | Write data; bits 5:0 are used |
| ei_pulse | input | 1 | Enable-interrupts strobe from the core |
| di_pulse | input | 1 | Disable-interrupts strobe from the core |
| iret_pulse | input | 1 | Interrupt-return strobe from the core |
| pend_clr | input | 1 | Software pending-clear strobe |
| pend_clr_sel | input | 6 | Pending bits to clear |
| ack | input | 1 | Core acknowledge of the current request |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | 8 | Vector address of the winning source |
| mask_q | output | 8 | Mask register: master enable, reserved zero, enables |
| pend_q | output | 6 | Pending flags |

## Verification
Directed pin sequences hold a level long enough to pass the filter, then apply a single-clock glitch. These separate a filter that counts samples from one that only synchronises, and they show that one pin really drives two separate lines by edge direction. Random timer strobes combine with random mask writes, enable, disable and return strobes, acknowledges and software clears. A bench model checks every cycle, so several sources are often pending at once: this separates true lowest-index priority from any other order. It also catches gating faults between the master enable and the per-source enables. Directed cycles place conflicting strobes in the same cycle to pin down the precedence rules.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the vectored interrupt controller.
package irqc_pkg;
    localparam int NSRC    = 6;  // request lines
    localparam int MASK_W  = 8;  // mask register width
    localparam int ME_BIT  = 7;  // master enable position
    localparam int RSV_BIT = 6;  // reserved, reads zero
    localparam int VEC_W   = 8;  // vector address width

    typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/irqc_edge_filter.sv
`timescale 1ns/1ps
// Synchronises one asynchronous pin and accepts a level change only after
// it has persisted for FILT_N consecutive samples. Emits one-cycle pulses
// for accepted rising and falling transitions.
// Assumes the pin idles at IDLE_LVL out of reset.
module irqc_edge_filter #(
    parameter int   FILT_N   = 2,
    parameter logic IDLE_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise_p,
    output logic fall_p
);
    localparam int CW = (FILT_N < 2) ? 1 : $clog2(FILT_N + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_N - 1);

    logic [1:0]    sync_q;
    logic          filt_q;
    logic [CW-1:0] run_q;

    // two-stage synchroniser against metastability
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= {2{IDLE_LVL}};
        else        sync_q <= {sync_q[0], pin};
    end

    // count consecutive differing samples and flip the filtered level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_q <= IDLE_LVL;
            run_q  <= '0;
            rise_p <= 1'b0;
            fall_p <= 1'b0;
        end else if (sync_q[1] != filt_q) begin
            if (run_q == LAST) begin
                filt_q <= sync_q[1];
                run_q  <= '0;
                rise_p <= sync_q[1];
                fall_p <= ~sync_q[1];
            end else begin
                run_q  <= run_q + 1'b1;
                rise_p <= 1'b0;
                fall_p <= 1'b0;
            end
        end else begin
            run_q  <= '0;
            rise_p <= 1'b0;
            fall_p <= 1'b0;
        end
    end
endmodule

// File: rtl/irqc_pending.sv
`timescale 1ns/1ps
// Pending flag bank: each flag is set by its event and cleared by the
// clear vector; a set in the same cycle as a clear leaves the flag set.
module irqc_pending
    import irqc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t set_v,
    input  src_vec_t clr_v,
    output src_vec_t pend
);
    // per-flag update with set dominant over clear
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr_v) | set_v;
    end
endmodule

// File: rtl/irqc_arbiter.sv
`timescale 1ns/1ps
// Fixed-priority selector: lowest set index of the eligible vector wins.
// Produces request, one-hot grant and vector VEC_BASE + VEC_STEP*index.
module irqc_arbiter
    import irqc_pkg::*;
#(
    parameter int VEC_BASE = 2,
    parameter int VEC_STEP = 2
) (
    input  src_vec_t         elig,
    output logic             req,
    output src_vec_t         grant,
    output logic [VEC_W-1:0] vec
);
    // scan from lowest priority up so the lowest index is written last
    always_comb begin
        grant = '0;
        vec   = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (elig[i]) begin
                grant = src_vec_t'(1) << i;
                vec   = VEC_W'(VEC_BASE + VEC_STEP * i);
            end
        end
    end

    // any eligible source raises the request
    assign req = |elig;
endmodule

// File: rtl/irq_vector_ctrl.sv
`timescale 1ns/1ps
// Vectored interrupt controller top. Combines timer strobes and filtered
// pin edges into pending flags, gates them by the mask register, and
// presents the winning vector. Mask register layout: bit 7 master enable,
// bit 6 reserved zero, bits 5:0 per-source enables.
// Assumes ack, ei, di and iret strobes are single-cycle pulses.
module irq_vector_ctrl
    import irqc_pkg::*;
#(
    parameter int FILT_N   = 2,
    parameter int VEC_BASE = 2,
    parameter int VEC_STEP = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          tmr_tick,
    input  logic [1:0]          ext_pin,
    input  logic                mask_wr,
    input  logic [MASK_W-1:0]   mask_wdata,
    input  logic                ei_pulse,
    input  logic                di_pulse,
    input  logic                iret_pulse,
    input  logic                pend_clr,
    input  logic [NSRC-1:0]     pend_clr_sel,
    input  logic                ack,
    output logic                irq_req,
    output logic [VEC_W-1:0]    irq_vec,
    output logic [MASK_W-1:0]   mask_q,
    output logic [NSRC-1:0]     pend_q
);
    localparam int NPIN = 2;

    logic [NPIN-1:0] pin_rise, pin_fall;
    logic            unused_pinb_rise;
    src_vec_t        set_v, clr_v, pend, en_q, elig, grant;
    logic            me_q, req, take;
    logic [VEC_W-1:0] vec;

    // one filter per external pin
    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        irqc_edge_filter #(.FILT_N(FILT_N), .IDLE_LVL(1'b1)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin    (ext_pin[p]),
            .rise_p (pin_rise[p]),
            .fall_p (pin_fall[p])
        );
    end

    assign unused_pinb_rise = pin_rise[1];

    // route events to request lines in priority order
    assign set_v = {tmr_tick[2], pin_rise[0], pin_fall[1],
                    tmr_tick[1], pin_fall[0], tmr_tick[0]};

    assign take  = ack & req;
    assign clr_v = (take ? grant : '0) | (pend_clr ? pend_clr_sel : '0);

    irqc_pending u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .set_v (set_v),
        .clr_v (clr_v),
        .pend  (pend)
    );

    // per-source enables: written only through the mask write strobe
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= '0;
        else if (mask_wr) en_q <= mask_wdata[NSRC-1:0];
    end

    // master enable: acknowledge and disable clear, enable and return set
    always_ff @(posedge clk) begin
        if (!rst_n)                     me_q <= 1'b0;
        else if (take || di_pulse)      me_q <= 1'b0;
        else if (ei_pulse || iret_pulse) me_q <= 1'b1;
    end

    assign elig = pend & en_q & {NSRC{me_q}};

    irqc_arbiter #(.VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_arb (
        .elig  (elig),
        .req   (req),
        .grant (grant),
        .vec   (vec)
    );

    assign irq_req = req;
    assign irq_vec = vec;
    assign pend_q  = pend;

    // assemble the visible mask register
    always_comb begin
        mask_q               = '0;
        mask_q[NSRC-1:0]     = en_q;
        mask_q[RSV_BIT]      = 1'b0;
        mask_q[ME_BIT]       = me_q;
    end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
`timescale 1ns/1ps
// Property checker attached to the controller top by bind.
module irq_vector_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       irq_req,
    input logic       ack,
    input logic       di_pulse,
    input logic       iret_pulse,
    input logic [7:0] irq_vec,
    input logic [7:0] mask_q,
    input logic [5:0] pend_q
);
    // R4
    req_needs_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> mask_q[7]);

    // R2
    vec_source_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (pend_q[3'((irq_vec >> 1) - 8'd1)] && mask_q[3'((irq_vec >> 1) - 8'd1)]));

    // R7
    ack_drops_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_req) |=> !mask_q[7]);

    // R8
    iret_sets_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iret_pulse && !di_pulse && !(ack && irq_req)) |=> mask_q[7]);

    // R5
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_q[6]);
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_req    (irq_req),
    .ack        (ack),
    .di_pulse   (di_pulse),
    .iret_pulse (iret_pulse),
    .irq_vec    (irq_vec),
    .mask_q     (mask_q),
    .pend_q     (pend_q)
);

// File: tb/irq_vector_ctrl_test.sv
`timescale 1ns/1ps
module irq_vector_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] tmr_tick = '0;
    logic [1:0] ext_pin = 2'b11;
    logic       mask_wr = 1'b0;
    logic [7:0] mask_wdata = '0;
    logic       ei_pulse = 1'b0, di_pulse = 1'b0, iret_pulse = 1'b0;
    logic       pend_clr = 1'b0;
    logic [5:0] pend_clr_sel = '0;
    logic       ack = 1'b0;
    logic       irq_req;
    logic [7:0] irq_vec, mask_q;
    logic [5:0] pend_q;

    int nchk = 0, nbad = 0;
    bit done = 1'b0;

    logic [5:0] m_pend, m_en;
    logic       m_me;

    always #2.5 clk = ~clk;

    irq_vector_ctrl uut (
        .clk(clk), .rst_n(rst_n), .tmr_tick(tmr_tick), .ext_pin(ext_pin),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata), .ei_pulse(ei_pulse),
        .di_pulse(di_pulse), .iret_pulse(iret_pulse), .pend_clr(pend_clr),
        .pend_clr_sel(pend_clr_sel), .ack(ack), .irq_req(irq_req),
        .irq_vec(irq_vec), .mask_q(mask_q), .pend_q(pend_q)
    );

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic int m_winner(logic [5:0] p, logic [5:0] e, logic me);
        for (int i = 0; i < 6; i++)
            if (me && p[i] && e[i]) return i;
        return -1;
    endfunction

    task automatic cmp_model();
        int w;
        w = m_winner(m_pend, m_en, m_me);
        check(mask_q == {m_me, 1'b0, m_en}, "R5/R6 mask_q", mask_q, {m_me, 1'b0, m_en});
        check(pend_q == m_pend, "R9/R10/R12 pend_q", pend_q, m_pend);
        check(irq_req == (w >= 0), "R4 irq_req", irq_req, (w >= 0));
        if (w >= 0)
            check(irq_vec == 8'(2 + 2 * w), "R2/R3 irq_vec", irq_vec, 2 + 2 * w);
    endtask

    task automatic rand_step();
        int w;
        logic [5:0] clrv, setv;
        tmr_tick     = {($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 8) == 0};
        mask_wr      = ($urandom % 16) == 0;
        mask_wdata   = 8'($urandom);
        ei_pulse     = ($urandom % 8) == 0;
        di_pulse     = ($urandom % 16) == 0;
        iret_pulse   = ($urandom % 16) == 0;
        ack          = ($urandom % 4) == 0;
        pend_clr     = ($urandom % 32) == 0;
        pend_clr_sel = 6'($urandom);
        w    = m_winner(m_pend, m_en, m_me);
        clrv = ((ack && w >= 0) ? (6'b1 << w) : 6'b0) | (pend_clr ? pend_clr_sel : 6'b0);
        setv = {tmr_tick[2], 2'b00, tmr_tick[1], 1'b0, tmr_tick[0]};
        tick(1);
        m_pend = (m_pend & ~clrv) | setv;
        if (mask_wr) m_en = mask_wdata[5:0];
        if ((ack && w >= 0) || di_pulse) m_me = 1'b0;
        else if (ei_pulse || iret_pulse) m_me = 1'b1;
        cmp_model();
    endtask

    task automatic idle_inputs();
        tmr_tick = '0; mask_wr = 0; ei_pulse = 0; di_pulse = 0;
        iret_pulse = 0; ack = 0; pend_clr = 0; pend_clr_sel = '0;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            nchk++; nbad++;
            $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
            $display("  test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        tick(3);
        // R1: values held during reset
        check(mask_q == 8'h00 && pend_q == 6'h00 && !irq_req, "R1 in reset",
              {mask_q, 2'b0, pend_q, 7'b0, irq_req}, 0);
        rst_n = 1'b1;
        tick(1);
        check(mask_q == 8'h00 && pend_q == 6'h00 && !irq_req, "R1 after reset",
              {mask_q, 2'b0, pend_q, 7'b0, irq_req}, 0);

        // R11/R2: falling edge on pin 0 sets bit 1 only; masked so no request (R9)
        ext_pin[0] = 1'b0; tick(8);
        check(pend_q == 6'b000010, "R11 pin0 fall", pend_q, 6'b000010);
        check(!irq_req, "R9 masked pending no req", irq_req, 0);
        ext_pin[0] = 1'b1; tick(8);
        check(pend_q == 6'b010010, "R11 pin0 rise", pend_q, 6'b010010);

        // R11: one-clock low glitch on pin 1 is rejected
        ext_pin[1] = 1'b0; tick(1); ext_pin[1] = 1'b1; tick(8);
        check(pend_q == 6'b010010, "R11 glitch rejected", pend_q, 6'b010010);
        ext_pin[1] = 1'b0; tick(8);
        check(pend_q == 6'b011010, "R11 pin1 fall", pend_q, 6'b011010);
        ext_pin[1] = 1'b1; tick(8);
        check(pend_q == 6'b011010, "R11 pin1 rise ignored", pend_q, 6'b011010);

        // R5: mask write, bit 7 and bit 6 stay low
        mask_wr = 1; mask_wdata = 8'hFF; tick(1); mask_wr = 0;
        check(mask_q == 8'h3F, "R5 mask write", mask_q, 8'h3F);
        check(!irq_req, "R4 master off", irq_req, 0);

        // R3: bits 1,3,4 pending; bit 1 wins with vector 4
        ei_pulse = 1; tick(1); ei_pulse = 0;
        check(irq_req && irq_vec == 8'd4, "R3 priority winner", irq_vec, 8'd4);

        // R7: acknowledge clears winner and master enable
        ack = 1; tick(1); ack = 0;
        check(pend_q == 6'b011000 && mask_q == 8'h3F, "R7 ack clears",
              {mask_q, pend_q}, {8'h3F, 6'b011000});

        // R7: acknowledge without request has no effect
        ack = 1; tick(1); ack = 0;
        check(pend_q == 6'b011000 && !irq_req, "R7 ack ignored", pend_q, 6'b011000);

        // R8: return re-enables, next winner bit 3 with vector 8
        iret_pulse = 1; tick(1); iret_pulse = 0;
        check(mask_q[7] && irq_vec == 8'd8, "R8 iret vector", irq_vec, 8'd8);

        // R6: disable wins over enable in the same cycle
        ei_pulse = 1; di_pulse = 1; tick(1); idle_inputs();
        check(!mask_q[7] && !irq_req, "R6 di over ei", mask_q, 8'h3F);

        // R12: event and clear of the same bit together leave it set
        tmr_tick[0] = 1; pend_clr = 1; pend_clr_sel = 6'b000001; tick(1); idle_inputs();
        check(pend_q == 6'b011001, "R12 set over clear", pend_q, 6'b011001);

        // R10: software clear of all bits
        pend_clr = 1; pend_clr_sel = 6'h3F; tick(1); idle_inputs();
        check(pend_q == 6'h00, "R10 sw clear", pend_q, 6'h00);

        // random phase against the bench model
        m_pend = '0; m_en = 6'h3F; m_me = 1'b0;
        for (int k = 0; k < 4000; k++) rand_step();
        idle_inputs();

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule